// File: doc/BRIEF.md
# SD Command Issue and Status Unit

This block sits on a 32-bit register bus. Software uses it to start SD/MMC commands and to collect what the card returns. Software first writes an argument word. It then writes a command word that carries the enable bit. The unit shifts a 48-bit command frame out on a single serial line, one bit per clock. If the command expects an answer, the unit opens a response window for a bounded number of cycles. A card-side responder answers inside that window with a response index, a 128-bit body and a CRC verdict. The unit latches the short or long response into four response words and records the outcome as a sticky status flag.

The eleven sticky flags share one bit layout across three registers: status, write-one-to-clear, and interrupt mask. A level interrupt is raised while any flag is both set and enabled. Two further status bits show live levels from the card socket: card absent and write protect. A neighbouring data path reports its own events through a pulse vector, and only the data-related positions of that vector are taken. A self-clearing soft reset bit in the command word does three things: it aborts any command in flight, it wipes the flags and the mask, and it reads back as 1 while the reset sequence runs.

Top module: `sdcmd_ctrl`

## Requirements
- R1: Writing address 0x00 with bit 9 set and bit 10 clear, while no command or reset is in progress, starts a command. Bits 5:0 give the index, bit 6 requests a response, bit 7 selects a long response and bit 8 marks an application command. Starting with the cycle after the write, `cmd_sdo` shifts out {0, 1, index, argument, seven 0 bits, 1}, MSB first, 48 bits, one bit per clock. `cmd_sdo` idles at 1.
- R2: A command with bit 6 clear sets status bit 6 (sent) when its frame ends and sets none of status bits 0, 2 and 4.
- R3: A command with bit 6 set holds `rsp_window` high for up to RSP_WAIT cycles after its frame. A valid reply with CRC good sets status bit 4 and a reply with CRC error sets bit 0. If no reply arrives, status bit 2 sets in the cycle after the last window cycle. Exactly one of these three bits is set.
- R4: A good short reply loads address 0x08 with body bits 31:0 and leaves 0x0C to 0x14 unchanged. Register 0x18 takes the reply index in bits 5:0 and the command's application bit in bit 6.
- R5: A good long reply loads 0x08, 0x0C, 0x10 and 0x14 with body bits 127:96, 95:64, 63:32 and 31:0 in that order.
- R6: A reply with CRC error, or a timeout, changes none of the response words and does not change 0x18.
- R7: A command-register write without bit 10, made while a command is in flight, is ignored. The register reads back its old value and no new frame starts.
- R8: Status bits 10:0 at 0x28 are sticky. Writing 1 to a bit at 0x2C clears that bit. An event arriving in the same cycle as the clear wins, and the bit stays set.
- R9: Status bit 11 is the live `card_absent` level and bit 12 is the live `card_wp` level. Any change of `card_absent` sets sticky bit 10.
- R10: The mask at 0x30 holds bits 10:0. `irq` is high exactly while some status bit 10:0 is set and its mask bit is 1.
- R11: Writing bit 10 at 0x00 aborts any command and wipes the sticky bits and the mask. It does not start a command even if bit 9 is also set. Bit 10 of 0x00 reads 1 for RST_CYCLES cycles and then 0.
- R12: A pulse on `xfer_evt` bit 1, 3, 5, 7, 8 or 9 sets the same sticky bit. The other `xfer_evt` bits have no effect.
- R13: The argument register 0x04 reads back what was written. Bits 9:0 of 0x00 read back the last accepted command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| card_absent | input | 1 | Socket level, 1 when no card is inserted |
| card_wp | input | 1 | Socket write-protect level |
| xfer_evt | input | 11 | Event pulses from the data path, in status bit positions |
| cmd_sdo | output | 1 | Serial command frame output |
| cmd_busy | output | 1 | A command is being sent or awaits its reply |
| rsp_window | output | 1 | Unit is waiting for a card reply |
| card_rsp_vld | input | 1 | Card reply present this cycle |
| card_rsp_crc_err | input | 1 | Reply CRC verdict, 1 means bad |
| card_rsp_idx | input | 6 | Index field returned by the card |
| card_rsp_body | input | 128 | Reply payload |
| irq | output | 1 | Level interrupt |

## Verification
The bound checker watches every cycle for five things: that each command ends in at most one outcome, that a started frame begins with its 0 start bit, that writes made during a command leave the stored command word alone, that the response words change only on a good reply, and that the flags and mask stay cleared while soft reset runs. Only the bench scenarios can show the rest: the exact 48-bit frame content, the cycle in which a timeout fires, the order of the long-response words, set beating clear, interrupt gating, and the length of the reset readback.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int FRAME_W = 48;
    localparam int STK_W   = 11;

    localparam logic [7:0] A_CMD  = 8'h00;
    localparam logic [7:0] A_ARG  = 8'h04;
    localparam logic [7:0] A_RSP0 = 8'h08;
    localparam logic [7:0] A_RSP1 = 8'h0C;
    localparam logic [7:0] A_RSP2 = 8'h10;
    localparam logic [7:0] A_RSP3 = 8'h14;
    localparam logic [7:0] A_RCMD = 8'h18;
    localparam logic [7:0] A_STAT = 8'h28;
    localparam logic [7:0] A_CLR  = 8'h2C;
    localparam logic [7:0] A_MASK = 8'h30;

    // command word fields
    localparam int C_NEED = 6;
    localparam int C_LONG = 7;
    localparam int C_APP  = 8;
    localparam int C_GO   = 9;
    localparam int C_SRST = 10;

    // sticky status positions driven by the command side
    localparam int S_RBAD = 0;
    localparam int S_RTMO = 2;
    localparam int S_ROK  = 4;
    localparam int S_SENT = 6;
    localparam int S_CHG  = 10;

    // positions accepted from the data path: 1,3,5,7,8,9
    localparam logic [STK_W-1:0] XFER_BITS = 11'h3AA;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_TX   = 2'd1,
        SQ_WAIT = 2'd2
    } sq_state_e;

endpackage

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
    import sdcmd_pkg::*;
#(
    parameter int RSP_WAIT = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        abort,
    input  logic        need_rsp,
    input  logic [5:0]  idx,
    input  logic [31:0] arg,
    input  logic        rsp_vld,
    input  logic        rsp_crc_err,
    output logic        sdo,
    output logic        busy,
    output logic        window,
    output logic        ev_sent,
    output logic        ev_ok,
    output logic        ev_bad,
    output logic        ev_tmo
);
    localparam int CNT_MAX = (FRAME_W > RSP_WAIT) ? FRAME_W : RSP_WAIT;
    localparam int CNT_W   = $clog2(CNT_MAX) + 1;

    typedef struct packed {
        sq_state_e          state;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sh;
        logic               need;
    } seq_s;

    localparam seq_s SEQ_RST = '{state: SQ_IDLE, cnt: '0, sh: '1, need: 1'b0};

    seq_s s_d, s_q;

    always_comb begin
        s_d     = s_q;
        ev_sent = 1'b0;
        ev_ok   = 1'b0;
        ev_bad  = 1'b0;
        ev_tmo  = 1'b0;
        case (s_q.state)
            SQ_IDLE: begin
                if (start) begin
                    s_d.state = SQ_TX;
                    s_d.cnt   = '0;
                    s_d.sh    = {2'b01, idx, arg, 7'd0, 1'b1};
                    s_d.need  = need_rsp;
                end
            end
            SQ_TX: begin
                s_d.sh = {s_q.sh[FRAME_W-2:0], 1'b1};
                if (s_q.cnt == CNT_W'(FRAME_W - 1)) begin
                    s_d.cnt = '0;
                    if (s_q.need) begin
                        s_d.state = SQ_WAIT;
                    end else begin
                        s_d.state = SQ_IDLE;
                        ev_sent   = 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            SQ_WAIT: begin
                if (rsp_vld) begin
                    s_d.state = SQ_IDLE;
                    ev_bad    = rsp_crc_err;
                    ev_ok     = !rsp_crc_err;
                end else if (s_q.cnt == CNT_W'(RSP_WAIT - 1)) begin
                    s_d.state = SQ_IDLE;
                    ev_tmo    = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d = SEQ_RST;
        endcase
        if (abort) begin
            s_d     = SEQ_RST;
            ev_sent = 1'b0;
            ev_ok   = 1'b0;
            ev_bad  = 1'b0;
            ev_tmo  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SEQ_RST;
        else        s_q <= s_d;
    end

    assign sdo    = (s_q.state == SQ_TX) ? s_q.sh[FRAME_W-1] : 1'b1;
    assign busy   = (s_q.state != SQ_IDLE);
    assign window = (s_q.state == SQ_WAIT);

endmodule

// File: rtl/sdcmd_stat.sv
module sdcmd_stat
    import sdcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STK_W-1:0] ev_set,
    input  logic             clr_wr,
    input  logic [STK_W-1:0] clr_bits,
    input  logic             mask_wr,
    input  logic [STK_W-1:0] mask_bits,
    input  logic             wipe,
    output logic [STK_W-1:0] sticky,
    output logic [STK_W-1:0] mask,
    output logic             irq
);
    typedef struct packed {
        logic [STK_W-1:0] sticky;
        logic [STK_W-1:0] mask;
    } stat_s;

    stat_s t_d, t_q;

    always_comb begin
        t_d = t_q;
        // an event in the same cycle outranks the clear
        t_d.sticky = (t_q.sticky & ~(clr_wr ? clr_bits : '0)) | ev_set;
        if (mask_wr) t_d.mask = mask_bits;
        if (wipe) begin
            t_d.sticky = '0;
            t_d.mask   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign sticky = t_q.sticky;
    assign mask   = t_q.mask;
    assign irq    = |(t_q.sticky & t_q.mask);

endmodule

// File: rtl/sdcmd_ctrl.sv
module sdcmd_ctrl
    import sdcmd_pkg::*;
#(
    parameter int RSP_WAIT   = 64,
    parameter int RST_CYCLES = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic [7:0]   bus_addr,
    input  logic [31:0]  bus_wdata,
    output logic [31:0]  bus_rdata,
    input  logic         card_absent,
    input  logic         card_wp,
    input  logic [10:0]  xfer_evt,
    output logic         cmd_sdo,
    output logic         cmd_busy,
    output logic         rsp_window,
    input  logic         card_rsp_vld,
    input  logic         card_rsp_crc_err,
    input  logic [5:0]   card_rsp_idx,
    input  logic [127:0] card_rsp_body,
    output logic         irq
);
    localparam int RCNT_W = $clog2(RST_CYCLES + 1);
    localparam int NWORDS = 4;

    typedef struct packed {
        logic [9:0]              cmd;
        logic [31:0]             arg;
        logic [NWORDS-1:0][31:0] rsp;
        logic [6:0]              rcmd;
        logic                    rst_busy;
        logic [RCNT_W-1:0]       rst_cnt;
        logic                    card_prev;
    } top_s;

    top_s q, d;

    logic             seq_busy, go, srst_req, wr_cmd, busy_any;
    logic             ev_sent, ev_ok, ev_bad, ev_tmo, wipe;
    logic [STK_W-1:0] ev_set, sticky, mask;

    assign wr_cmd   = bus_wr && (bus_addr == A_CMD);
    assign busy_any = seq_busy || q.rst_busy;
    assign srst_req = wr_cmd && bus_wdata[C_SRST];
    assign go       = wr_cmd && !bus_wdata[C_SRST] && bus_wdata[C_GO] && !busy_any;
    assign wipe     = srst_req || q.rst_busy;

    sdcmd_seq #(.RSP_WAIT(RSP_WAIT)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (go),
        .abort       (wipe),
        .need_rsp    (bus_wdata[C_NEED]),
        .idx         (bus_wdata[5:0]),
        .arg         (q.arg),
        .rsp_vld     (card_rsp_vld),
        .rsp_crc_err (card_rsp_crc_err),
        .sdo         (cmd_sdo),
        .busy        (seq_busy),
        .window      (rsp_window),
        .ev_sent     (ev_sent),
        .ev_ok       (ev_ok),
        .ev_bad      (ev_bad),
        .ev_tmo      (ev_tmo)
    );

    always_comb begin
        ev_set         = xfer_evt & XFER_BITS;
        ev_set[S_RBAD] = ev_bad;
        ev_set[S_RTMO] = ev_tmo;
        ev_set[S_ROK]  = ev_ok;
        ev_set[S_SENT] = ev_sent;
        ev_set[S_CHG]  = (card_absent != q.card_prev);
    end

    sdcmd_stat stat_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_set    (ev_set),
        .clr_wr    (bus_wr && (bus_addr == A_CLR)),
        .clr_bits  (bus_wdata[STK_W-1:0]),
        .mask_wr   (bus_wr && (bus_addr == A_MASK)),
        .mask_bits (bus_wdata[STK_W-1:0]),
        .wipe      (wipe),
        .sticky    (sticky),
        .mask      (mask),
        .irq       (irq)
    );

    always_comb begin
        d           = q;
        d.card_prev = card_absent;
        if (bus_wr && (bus_addr == A_ARG)) d.arg = bus_wdata;
        if (wr_cmd && !bus_wdata[C_SRST] && !busy_any) d.cmd = bus_wdata[9:0];
        if (srst_req) begin
            d.rst_busy = 1'b1;
            d.rst_cnt  = '0;
        end else if (q.rst_busy) begin
            if (q.rst_cnt == RCNT_W'(RST_CYCLES - 1)) d.rst_busy = 1'b0;
            else d.rst_cnt = q.rst_cnt + 1'b1;
        end
        if (ev_ok) begin
            d.rcmd = {q.cmd[C_APP], card_rsp_idx};
            if (q.cmd[C_LONG]) begin
                for (int w = 0; w < NWORDS; w++)
                    d.rsp[w] = card_rsp_body[(NWORDS-1-w)*32 +: 32];
            end else begin
                d.rsp[0] = card_rsp_body[31:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.card_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (bus_addr)
            A_CMD:   bus_rdata = {21'd0, q.rst_busy, q.cmd};
            A_ARG:   bus_rdata = q.arg;
            A_RSP0:  bus_rdata = q.rsp[0];
            A_RSP1:  bus_rdata = q.rsp[1];
            A_RSP2:  bus_rdata = q.rsp[2];
            A_RSP3:  bus_rdata = q.rsp[3];
            A_RCMD:  bus_rdata = {25'd0, q.rcmd};
            A_STAT:  bus_rdata = {19'd0, card_wp, card_absent, sticky};
            A_MASK:  bus_rdata = {21'd0, mask};
            default: bus_rdata = 32'd0;
        endcase
    end

    assign cmd_busy = seq_busy;

endmodule

// File: rtl/sdcmd_ctrl_chk.sv
module sdcmd_ctrl_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_wr,
    input logic [7:0]   bus_addr,
    input logic [31:0]  bus_wdata,
    input logic         seq_busy,
    input logic         go,
    input logic         cmd_sdo,
    input logic         cmd_busy,
    input logic         rst_busy,
    input logic [9:0]   cmd_q,
    input logic [127:0] rsp_flat,
    input logic [6:0]   rcmd_q,
    input logic [10:0]  sticky,
    input logic [10:0]  mask,
    input logic         ev_sent,
    input logic         ev_ok,
    input logic         ev_bad,
    input logic         ev_tmo
);
    p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_sent, ev_ok, ev_bad, ev_tmo}));

    p_start_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (cmd_busy && !cmd_sdo));

    p_busy_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h00 && !bus_wdata[10] && seq_busy) |=> $stable(cmd_q));

    p_resp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_ok |=> ($stable(rsp_flat) && $stable(rcmd_q)));

    p_reset_wipe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_busy |=> (sticky == 11'd0 && mask == 11'd0));
endmodule

bind sdcmd_ctrl sdcmd_ctrl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .seq_busy  (seq_busy),
    .go        (go),
    .cmd_sdo   (cmd_sdo),
    .cmd_busy  (cmd_busy),
    .rst_busy  (q.rst_busy),
    .cmd_q     (q.cmd),
    .rsp_flat  (q.rsp),
    .rcmd_q    (q.rcmd),
    .sticky    (sticky),
    .mask      (mask),
    .ev_sent   (ev_sent),
    .ev_ok     (ev_ok),
    .ev_bad    (ev_bad),
    .ev_tmo    (ev_tmo)
);

// File: tb/sdcmd_ctrl_tb_top.sv
module sdcmd_ctrl_tb_top;
    localparam int RSP_WAIT   = 64;
    localparam int RST_CYCLES = 8;

    localparam logic [7:0] CMD = 8'h00, ARG = 8'h04, RSP0 = 8'h08, RSP1 = 8'h0C,
                           RSP2 = 8'h10, RSP3 = 8'h14, RCMD = 8'h18, STAT = 8'h28,
                           CLR = 8'h2C, MSK = 8'h30;

    // act: 0 no reply expected, 1 good reply, 2 CRC error, 3 silent card
    typedef struct packed {
        logic [10:0] cmd;
        logic [31:0] arg;
        logic [1:0]  act;
        logic [5:0]  ridx;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{11'h200, 32'h0000_0000, 2'd0, 6'd0},
        '{11'h248, 32'h0000_01AA, 2'd1, 6'd8},
        '{11'h369, 32'h40FF_8000, 2'd1, 6'h3F},
        '{11'h2C2, 32'h0000_0000, 2'd1, 6'h3F},
        '{11'h24D, 32'h1234_0000, 2'd2, 6'd13},
        '{11'h277, 32'h0001_0000, 2'd3, 6'd0},
        '{11'h289, 32'hDEAD_BEEF, 2'd0, 6'd0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = 8'h0;
    logic [31:0]  bus_wdata = 32'h0;
    logic [31:0]  bus_rdata;
    logic         card_absent = 1'b1;
    logic         card_wp = 1'b0;
    logic [10:0]  xfer_evt = 11'h0;
    logic         cmd_sdo, cmd_busy, rsp_window, irq;
    logic         card_rsp_vld = 1'b0;
    logic         card_rsp_crc_err = 1'b0;
    logic [5:0]   card_rsp_idx = 6'h0;
    logic [127:0] card_rsp_body = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] m_rsp [4];
    logic [6:0]  m_rcmd;

    always #4 clk = ~clk;

    sdcmd_ctrl #(.RSP_WAIT(RSP_WAIT), .RST_CYCLES(RST_CYCLES)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .card_absent(card_absent),
        .card_wp(card_wp), .xfer_evt(xfer_evt), .cmd_sdo(cmd_sdo),
        .cmd_busy(cmd_busy), .rsp_window(rsp_window), .card_rsp_vld(card_rsp_vld),
        .card_rsp_crc_err(card_rsp_crc_err), .card_rsp_idx(card_rsp_idx),
        .card_rsp_body(card_rsp_body), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    function automatic logic [127:0] body_of(input logic [31:0] a, input logic [5:0] i);
        return {a ^ 32'hC001_0000, a + 32'h11, ~a, {26'd0, i} ^ 32'h5A5A_0000};
    endfunction

    task automatic run_vec(input vec_t v);
        logic [47:0]  got_frame, exp_frame;
        logic [31:0]  r, exp_stat;
        logic [127:0] body;
        wr(CLR, 32'h7FF);
        wr(ARG, v.arg);
        wr(CMD, {21'd0, v.cmd});
        for (int i = 0; i < 48; i++) begin
            got_frame[47-i] = cmd_sdo;
            @(negedge clk);
        end
        exp_frame = {2'b01, v.cmd[5:0], v.arg, 7'd0, 1'b1};
        check("R1 frame", {16'd0, got_frame}, {16'd0, exp_frame});
        rd(ARG, r);
        check("R13 arg readback", {32'd0, r}, {32'd0, v.arg});
        body = body_of(v.arg, v.ridx);
        if (v.cmd[6]) begin
            check("R3 window open", {63'd0, rsp_window}, 64'd1);
            if (v.act == 2'd3) begin
                repeat (RSP_WAIT - 1) @(negedge clk);
                rd(STAT, r);
                check("R3 no timeout before limit", {63'd0, r[2]}, 64'd0);
                check("R3 window at limit", {63'd0, rsp_window}, 64'd1);
                @(negedge clk);
            end else begin
                repeat (3) @(negedge clk);
                card_rsp_vld = 1'b1;
                card_rsp_crc_err = (v.act == 2'd2);
                card_rsp_idx = v.ridx;
                card_rsp_body = body;
                @(negedge clk);
                card_rsp_vld = 1'b0;
                card_rsp_body = '0;
                if (v.act == 2'd1) begin
                    m_rcmd = {v.cmd[8], v.ridx};
                    if (v.cmd[7]) begin
                        m_rsp[0] = body[127:96]; m_rsp[1] = body[95:64];
                        m_rsp[2] = body[63:32];  m_rsp[3] = body[31:0];
                    end else begin
                        m_rsp[0] = body[31:0];
                    end
                end
            end
        end
        check("R3 window closed", {63'd0, rsp_window}, 64'd0);
        check("R2 R3 idle after command", {63'd0, cmd_busy}, 64'd0);
        exp_stat = {19'd0, card_wp, card_absent, 11'd0};
        if (!v.cmd[6])           exp_stat[6] = 1'b1;
        else if (v.act == 2'd1)  exp_stat[4] = 1'b1;
        else if (v.act == 2'd2)  exp_stat[0] = 1'b1;
        else                     exp_stat[2] = 1'b1;
        rd(STAT, r);
        check(v.cmd[6] ? "R3 outcome status" : "R2 sent status", {32'd0, r}, {32'd0, exp_stat});
        rd(CMD, r);
        check("R13 command readback", {32'd0, r}, {53'd0, v.cmd});
        rd(RSP0, r); check("R4 R5 R6 response word 0", {32'd0, r}, {32'd0, m_rsp[0]});
        rd(RSP1, r); check("R5 R6 response word 1", {32'd0, r}, {32'd0, m_rsp[1]});
        rd(RSP2, r); check("R5 R6 response word 2", {32'd0, r}, {32'd0, m_rsp[2]});
        rd(RSP3, r); check("R5 R6 response word 3", {32'd0, r}, {32'd0, m_rsp[3]});
        rd(RCMD, r); check("R4 R6 response command", {32'd0, r}, {57'd0, m_rcmd});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        for (int w = 0; w < 4; w++) m_rsp[w] = 32'd0;
        m_rcmd = 7'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(STAT, r); check("R9 reset status", {32'd0, r}, 64'h800);
        rd(CMD, r);  check("R13 reset command", {32'd0, r}, 64'd0);
        rd(MSK, r);  check("R10 reset mask", {32'd0, r}, 64'd0);
        check("R1 idle line", {62'd0, cmd_sdo, irq}, 64'h2);

        // table of command scenarios
        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R7: command write during flight ignored
        wr(CLR, 32'h7FF);
        wr(CMD, 32'h251);
        repeat (5) @(negedge clk);
        wr(CMD, 32'h203);
        rd(CMD, r);
        check("R7 busy write ignored", {32'd0, r}, 64'h251);
        for (int k = 0; k < 300 && cmd_busy; k++) @(negedge clk);
        @(negedge clk);
        rd(STAT, r);
        check("R7 only first command completed", {32'd0, r}, 64'h804);

        // R12: data path events, only accepted positions
        wr(CLR, 32'h7FF);
        @(negedge clk); xfer_evt = 11'h7FF;
        @(negedge clk); xfer_evt = 11'h0;
        rd(STAT, r);
        check("R12 data events filtered", {32'd0, r}, 64'hBAA);

        // R8: set wins over simultaneous clear
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = CLR; bus_wdata = 32'h00A; xfer_evt = 11'h002;
        @(negedge clk);
        bus_wr = 1'b0; xfer_evt = 11'h0;
        rd(STAT, r);
        check("R8 set beats clear", {32'd0, r}, 64'hBA2);

        // R10: interrupt gating
        wr(MSK, 32'h080);
        rd(MSK, r); check("R10 mask readback", {32'd0, r}, 64'h080);
        check("R10 irq enabled flag", {63'd0, irq}, 64'd1);
        wr(MSK, 32'h400);
        check("R10 irq masked", {63'd0, irq}, 64'd0);

        // R9: card insertion sets change, live detect level
        @(negedge clk); card_absent = 1'b0;
        @(negedge clk);
        rd(STAT, r);
        check("R9 change and live detect", {32'd0, r[11:10]}, 64'h1);
        check("R10 irq on change", {63'd0, irq}, 64'd1);
        wr(CLR, 32'h400);
        check("R8 R10 clear drops irq", {63'd0, irq}, 64'd0);
        @(negedge clk); xfer_evt = 11'h080;
        @(negedge clk); xfer_evt = 11'h0;
        wr(MSK, 32'h480);

        // R11: soft reset mid-command
        wr(CMD, 32'h245);
        repeat (3) @(negedge clk);
        wr(CMD, 32'h600);
        rd(CMD, r);
        check("R11 reset bit reads one", {32'd0, r}, 64'h645);
        check("R11 command aborted", {62'd0, cmd_busy, cmd_sdo}, 64'h1);
        repeat (RST_CYCLES - 1) @(negedge clk);
        rd(CMD, r);
        check("R11 reset bit held", {63'd0, r[10]}, 64'd1);
        @(negedge clk);
        rd(CMD, r);
        check("R11 reset bit self clears", {32'd0, r}, 64'h245);
        rd(STAT, r); check("R11 sticky wiped", {32'd0, r}, 64'h0);
        rd(MSK, r);  check("R11 mask wiped", {32'd0, r}, 64'h0);
        check("R11 no command started", {62'd0, cmd_busy, irq}, 64'h0);
        card_wp = 1'b1;
        rd(STAT, r); check("R9 live write protect", {32'd0, r}, 64'h1000);

        // after reset the unit issues again
        run_vec(VECS[0]);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule